// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and makes its exceptions precise. It keeps a small shadow of each pipeline latch: a valid bit, the instruction's PC and an eight-bit cause vector. Every stage that can detect a fault drives strobes for the instruction it currently holds. Those strobes are ORed into the vector as the instruction moves to the next stage, so every cause stays attached to the instruction that raised it.

No cause takes effect when it is raised. The vector is examined only when its instruction reaches writeback. Because instructions arrive there in program order, the oldest faulting instruction is always the one serviced, even when a younger instruction faulted first in time. While a fault is pending, the block withholds the register-file write enable and the data-memory write enable from the faulting instruction and from every instruction behind it. When the fault reaches writeback, the block raises a trap redirect for fetch. It reports which stages held valid younger work so that the pipeline can drop it, and it captures the faulting PC and a cause code.

The handler behaviour after the redirect is outside the scope of this block.

Top module: `pet_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, `trap_go`, `rf_wr_ok`, `dm_wr_ok` and `flush_mask` are 0, and `epc` and `exc_code` are 0.
- R2: An instruction loaded through `fetch_valid` at one clock edge is in IF for the next cycle, in ID one cycle later, then in EX, then in MEM, then in WB. Strobes raised for it in any stage are kept with it until WB.
- R3: The cause vector has these bits: bit 0 fetch page fault, bit 1 fetch misaligned, bit 2 fetch protection, bit 3 illegal opcode, bit 4 arithmetic, bit 5 data page fault, bit 6 data misaligned, bit 7 data protection. `exc_code` is one plus the index of the lowest set bit, so the cause from the earliest stage wins. Code 0 means no cause.
- R4: `trap_go` is 1 in exactly the cycle in which a valid instruction with a non-empty vector occupies WB, and at no other time.
- R5: `rf_wr_ok` is 1 exactly when a valid instruction with an empty vector occupies WB.
- R6: `dm_wr_ok` is 1 exactly when a valid instruction occupies MEM, its vector is empty, no MEM strobe is raised in that cycle, and no trap is being taken in WB.
- R7: In a trap cycle, `flush_mask` bit 0 (IF), bit 1 (ID), bit 2 (EX) and bit 3 (MEM) show which stages held valid instructions. All of these instructions and the one fetched in that cycle are discarded, so none of them later writes or traps. Outside trap cycles `flush_mask` is 0.
- R8: On the edge that ends a trap cycle, `epc` takes the PC of the trapping instruction and `exc_code` takes its code. Both hold their values at all other edges.
- R9: An older instruction that faults late is trapped before a younger instruction that faulted earlier in time. The younger one is discarded without a trap.
- R10: Strobes raised for a stage that holds no valid instruction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction enters IF at this edge |
| fetch_pc | input | PC_W | PC of the entering instruction |
| if_exc | input | 3 | IF strobes: [0] page fault, [1] misaligned, [2] protection |
| id_exc | input | 1 | ID strobe: illegal opcode |
| ex_exc | input | 1 | EX strobe: arithmetic exception |
| mem_exc | input | 3 | MEM strobes: [0] page fault, [1] misaligned, [2] protection |
| rf_wr_ok | output | 1 | Register-file write permitted for the WB instruction |
| dm_wr_ok | output | 1 | Data-memory write permitted for the MEM instruction |
| flush_mask | output | 4 | Valid stages discarded by the trap, bit 0 IF to bit 3 MEM |
| trap_go | output | 1 | Redirect fetch to the trap entry |
| epc | output | PC_W | PC of the last trapped instruction |
| exc_code | output | 4 | Cause code of the last trap |

## Verification
The key corner case is a pair of neighbours in which the younger one faults in fetch before the older one faults in memory. A design that acted on a cause as soon as it was raised would trap on the younger PC, and one that did not discard the younger instruction would trap a second time. Every combination of the eight cause bits on a single instruction is swept, which exposes a priority encoder that picks the wrong bit or loses causes between latches. Every pairing of fetch and memory strobes on two back-to-back instructions is also swept. This catches a store enable that ignores the same-cycle memory strobe or the older trap. A full pipeline that traps in the middle checks that all four flush bits are set and that no discarded instruction retires. Strobes on an empty pipeline must leave the saved PC and code unchanged.

// File: rtl/pet_pkg.sv
package pet_pkg;
  localparam int NSTG   = 5;
  localparam int NCAUSE = 8;
  localparam int CODE_W = $clog2(NCAUSE + 1);

  localparam int S_IF  = 0;
  localparam int S_ID  = 1;
  localparam int S_EX  = 2;
  localparam int S_MEM = 3;
  localparam int S_WB  = 4;

  // cause bit positions, earliest stage lowest
  localparam int C_IF_BASE  = 0;
  localparam int C_ILLEGAL  = 3;
  localparam int C_ARITH    = 4;
  localparam int C_MEM_BASE = 5;

  typedef logic [NCAUSE-1:0] cvec_t;

  // code = 1 + index of lowest set bit, 0 when empty
  function automatic logic [CODE_W-1:0] cause_code(cvec_t v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/pet_stage.sv
module pet_stage
  import pet_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  cvec_t           in_vec,
  input  cvec_t           raise,
  output logic            valid,
  output logic [PC_W-1:0] pc,
  output cvec_t           vec
);
  // strobes only count when a real instruction is present
  cvec_t merged;
  assign merged = in_valid ? (in_vec | raise) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      pc    <= '0;
      vec   <= '0;
    end else begin
      valid <= in_valid & ~kill;
      pc    <= in_pc;
      vec   <= merged;
    end
  end

  p_kill_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !valid);

  p_empty_stage_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (vec == '0));
endmodule

// File: rtl/pet_trap_unit.sv
module pet_trap_unit
  import pet_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_valid,
  input  logic [PC_W-1:0]   wb_pc,
  input  cvec_t             wb_vec,
  output logic              trap_go,
  output logic              rf_wr_ok,
  output logic [PC_W-1:0]   epc,
  output logic [CODE_W-1:0] exc_code
);
  logic wb_fault;
  logic [CODE_W-1:0] wb_code;

  assign wb_fault = |wb_vec;
  assign wb_code  = cause_code(wb_vec);
  assign trap_go  = wb_valid & wb_fault;
  assign rf_wr_ok = wb_valid & ~wb_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc      <= '0;
      exc_code <= '0;
    end else if (trap_go) begin
      epc      <= wb_pc;
      exc_code <= wb_code;
    end
  end

  p_epc_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> (epc == $past(wb_pc)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_go |=> ($stable(epc) && $stable(exc_code)));

  p_code_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> (exc_code != '0));

  p_write_or_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_go && rf_wr_ok));
endmodule

// File: rtl/pet_tracker.sv
module pet_tracker
  import pet_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [2:0]        if_exc,
  input  logic              id_exc,
  input  logic              ex_exc,
  input  logic [2:0]        mem_exc,
  output logic              rf_wr_ok,
  output logic              dm_wr_ok,
  output logic [NSTG-2:0]   flush_mask,
  output logic              trap_go,
  output logic [PC_W-1:0]   epc,
  output logic [CODE_W-1:0] exc_code
);
  logic            st_valid [NSTG];
  logic [PC_W-1:0] st_pc    [NSTG];
  cvec_t           st_vec   [NSTG];
  cvec_t           raise    [NSTG-1];
  logic            any_live;
  logic            mem_hit;

  // place each stage's strobes at their bit positions
  always_comb begin
    for (int s = 0; s < NSTG - 1; s++) raise[s] = '0;
    raise[S_IF][C_IF_BASE +: 3]   = if_exc;
    raise[S_ID][C_ILLEGAL]        = id_exc;
    raise[S_EX][C_ARITH]          = ex_exc;
    raise[S_MEM][C_MEM_BASE +: 3] = mem_exc;
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    logic            iv;
    logic [PC_W-1:0] ip;
    cvec_t           ivec;
    cvec_t           ir;
    if (g == 0) begin : g_head
      assign iv   = fetch_valid;
      assign ip   = fetch_pc;
      assign ivec = '0;
      assign ir   = '0;
    end else begin : g_body
      assign iv   = st_valid[g-1];
      assign ip   = st_pc[g-1];
      assign ivec = st_vec[g-1];
      assign ir   = raise[g-1];
    end
    pet_stage #(.PC_W(PC_W)) u_stg (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (trap_go),
      .in_valid (iv),
      .in_pc    (ip),
      .in_vec   (ivec),
      .raise    (ir),
      .valid    (st_valid[g]),
      .pc       (st_pc[g]),
      .vec      (st_vec[g])
    );
  end

  pet_trap_unit #(.PC_W(PC_W)) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_valid (st_valid[S_WB]),
    .wb_pc    (st_pc[S_WB]),
    .wb_vec   (st_vec[S_WB]),
    .trap_go  (trap_go),
    .rf_wr_ok (rf_wr_ok),
    .epc      (epc),
    .exc_code (exc_code)
  );

  // store needs a clean history, no fault now, and no older trap
  assign mem_hit  = |mem_exc;
  assign dm_wr_ok = st_valid[S_MEM] & ~(|st_vec[S_MEM]) & ~mem_hit & ~trap_go;

  always_comb begin
    any_live = 1'b0;
    for (int s = 0; s < NSTG; s++) any_live = any_live | st_valid[s];
    for (int s = 0; s < NSTG - 1; s++) flush_mask[s] = trap_go & st_valid[s];
  end

  p_store_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |-> !dm_wr_ok);

  p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> !any_live);

  p_store_needs_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wr_ok |-> !mem_hit);
endmodule

// File: tb/tb_pet_tracker.sv
`timescale 1ns/1ps
module tb_pet_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic [2:0]  if_exc;
  logic        id_exc;
  logic        ex_exc;
  logic [2:0]  mem_exc;
  logic        rf_wr_ok, dm_wr_ok, trap_go;
  logic [3:0]  flush_mask;
  logic [31:0] epc;
  logic [3:0]  exc_code;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_epc;
  logic [3:0]  exp_code;

  always #2 clk = ~clk;

  pet_tracker #(.PC_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .if_exc(if_exc), .id_exc(id_exc), .ex_exc(ex_exc), .mem_exc(mem_exc),
    .rf_wr_ok(rf_wr_ok), .dm_wr_ok(dm_wr_ok), .flush_mask(flush_mask),
    .trap_go(trap_go), .epc(epc), .exc_code(exc_code)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] low_code(logic [7:0] v);
    for (int j = 0; j < 8; j++) if (v[j]) return 4'(j + 1);
    return 4'd0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    fetch_valid = 1'b0; if_exc = '0; id_exc = 1'b0; ex_exc = 1'b0; mem_exc = '0;
  endtask

  // one instruction carrying cause vector v
  task automatic single(logic [7:0] v, logic [31:0] p);
    tick(); quiet(); fetch_valid = 1'b1; fetch_pc = p;
    tick(); quiet(); if_exc = v[2:0];
    tick(); quiet(); id_exc = v[3];
    tick(); quiet(); ex_exc = v[4];
    tick(); quiet(); mem_exc = v[7:5]; #1;
    chk("R6 store enable single", 32'(dm_wr_ok), 32'(v == 8'd0));
    tick(); quiet(); #1;
    chk("R4 trap at WB single", 32'(trap_go), 32'(v != 8'd0));
    chk("R5 reg write single", 32'(rf_wr_ok), 32'(v == 8'd0));
    chk("R7 mask empty pipe", 32'(flush_mask), 32'd0);
    if (v != 8'd0) begin exp_epc = p; exp_code = low_code(v); end
    tick(); quiet(); #1;
    chk("R8 epc single", epc, exp_epc);
    chk("R3 code single", 32'(exc_code), 32'(exp_code));
  endtask

  // A (older) with MEM strobes am, B (younger) with IF strobes bi
  task automatic pair(logic [2:0] am, logic [2:0] bi, logic [31:0] pa);
    logic af, bf;
    af = (am != 3'd0); bf = (bi != 3'd0);
    for (int t = 0; t < 8; t++) begin
      tick(); quiet();
      fetch_valid = (t < 2);
      fetch_pc = pa + 32'(4 * t);
      if (t == 2) if_exc = bi;
      if (t == 4) mem_exc = am;
      #1;
      if (t == 4) chk("R6 older store", 32'(dm_wr_ok), 32'(!af));
      if (t == 5) begin
        chk("R9 older trap first", 32'(trap_go), 32'(af));
        chk("R5 older retire", 32'(rf_wr_ok), 32'(!af));
        chk("R6 younger store gated", 32'(dm_wr_ok), 32'(!af && !bf));
        chk("R7 mask younger in MEM", 32'(flush_mask), af ? 32'h8 : 32'h0);
        if (af) begin exp_epc = pa; exp_code = low_code({am, 5'd0}); end
      end
      if (t == 6) begin
        chk("R8 epc pair", epc, exp_epc);
        chk("R3 code pair", 32'(exc_code), 32'(exp_code));
        chk("R9 younger trap", 32'(trap_go), 32'(!af && bf));
        chk("R5 younger retire", 32'(rf_wr_ok), 32'(!af && !bf));
        if (!af && bf) begin exp_epc = pa + 32'd4; exp_code = low_code({5'd0, bi}); end
      end
      if (t == 7) begin
        chk("R7 flushed never traps", 32'(trap_go), 32'd0);
        chk("R8 epc after pair", epc, exp_epc);
        chk("R3 code after pair", 32'(exc_code), 32'(exp_code));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_pc = '0; quiet();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 trap in reset", 32'(trap_go), 32'd0);
    chk("R1 reg write in reset", 32'(rf_wr_ok), 32'd0);
    chk("R1 store in reset", 32'(dm_wr_ok), 32'd0);
    chk("R1 mask in reset", 32'(flush_mask), 32'd0);
    chk("R1 epc in reset", epc, 32'd0);
    chk("R1 code in reset", 32'(exc_code), 32'd0);
    rst_n = 1'b1;
    exp_epc = '0; exp_code = '0;
    tick(); #1;
    chk("R1 trap after reset", 32'(trap_go), 32'd0);

    // R2 R3: every cause combination on one instruction
    for (int v = 0; v < 256; v++) single(8'(v), 32'h1000 + 32'(v * 16));

    // R9: every pairing of older MEM strobes and younger IF strobes
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        pair(3'(a), 3'(b), 32'h8000 + 32'((a * 8 + b) * 64));

    // R7: full pipeline, third instruction illegal
    for (int t = 0; t < 14; t++) begin
      tick(); quiet();
      fetch_valid = (t <= 6);
      fetch_pc = 32'h200 + 32'(4 * t);
      id_exc = (t == 4);
      #1;
      if (t == 4 || t == 5) chk("R6 clean store stream", 32'(dm_wr_ok), 32'd1);
      if (t == 5 || t == 6) chk("R5 older retire stream", 32'(rf_wr_ok), 32'd1);
      if (t == 6) chk("R6 faulted store stream", 32'(dm_wr_ok), 32'd0);
      if (t == 7) begin
        chk("R4 trap stream", 32'(trap_go), 32'd1);
        chk("R7 mask full", 32'(flush_mask), 32'hf);
      end
      if (t >= 8) begin
        chk("R7 no retire after flush", 32'(rf_wr_ok), 32'd0);
        chk("R7 no trap after flush", 32'(trap_go), 32'd0);
        chk("R7 no store after flush", 32'(dm_wr_ok), 32'd0);
        chk("R8 epc stream", epc, 32'h208);
        chk("R3 code illegal", 32'(exc_code), 32'd4);
      end
    end

    // R10: strobes with an empty pipeline
    exp_epc = epc; exp_code = exc_code;
    for (int t = 0; t < 8; t++) begin
      tick(); quiet();
      if_exc = 3'b111; id_exc = 1'b1; ex_exc = 1'b1; mem_exc = 3'b111;
      #1;
      chk("R10 no trap when empty", 32'(trap_go), 32'd0);
      chk("R10 no store when empty", 32'(dm_wr_ok), 32'd0);
      chk("R10 epc unchanged", epc, exp_epc);
    end
    tick(); quiet(); #1;
    chk("R10 code unchanged", 32'(exc_code), 32'(exp_code));

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule